// File: doc/BRIEF.md
# Two-Channel Edge Interval Timer

This block measures the time between a rising edge on a start input and a later rising edge on a stop input. A free-running counter is copied into a separate capture register for each channel on the first cycle in which that channel's qualified rising edge is seen. Software reads the two captured values and their difference, which is computed in hardware modulo the counter width. The counter is never reset for a measurement, so one counter wrap between the two edges does not matter.

Each input passes through a two-flop synchronizer and then an optional digital filter. The filter takes samples at a divided rate and changes its output level only after a run of equal samples that all differ from the current level. A capture on the stop channel raises the done flag. Any later edge on a channel that has already captured raises that channel's overcapture flag and leaves the stored value unchanged. Pulsing the clear input re-arms both channels.

Top module: `edge_interval_timer`

## Requirements
- R1: While reset is held and on its release, `done`, `start_ovr` and `stop_ovr` are 0 and both capture registers read 0.
- R2: With filter code 0 on both channels, if the start input rises at one clock edge and the stop input rises D clock edges later, then `interval` equals D. This also holds for D = 0.
- R3: `interval` is `stop_cap - start_cap` modulo 2^W, so a separation of more than 2^W cycles reads as that separation modulo 2^W.
- R4: `done` is set by a stop capture only. A start capture alone leaves `done` at 0. Once set, `done` stays set until `done_clr` is pulsed.
- R5: A rising edge on a channel that has already captured sets that channel's overcapture output and does not change its capture register.
- R6: A cycle with `done_clr` high clears `done`, `start_ovr` and `stop_ovr` on the next clock edge and re-arms both channels for a fresh capture.
- R7: A nonzero filter code c selects a divider and a run length N as follows: 1:(1,2) 2:(1,4) 3:(1,8) 4:(2,6) 5:(2,8) 6:(4,6) 7:(4,8) 8:(8,6) 9:(8,8) 10:(16,4) 11:(16,6) 12:(16,8) 13:(32,4) 14:(32,6) 15:(32,8). Relative to code 0, a filtered channel captures between (N-1)*div+1 and N*div cycles later.
- R8: A high pulse shorter than (N-1)*div+1 cycles on a filtered channel produces no capture. For example, a 1-cycle pulse under code 1 or a 100-cycle pulse under code 15 produces none.
- R9: A falling edge on an input never captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Start event input, asynchronous |
| stop_in | input | 1 | Stop (response) event input, asynchronous |
| start_fcode | input | 4 | Filter code for the start channel |
| stop_fcode | input | 4 | Filter code for the stop channel |
| done_clr | input | 1 | Clears the flags and re-arms the channels |
| done | output | 1 | Stop channel has captured |
| start_ovr | output | 1 | Extra edge on the start channel after its capture |
| stop_ovr | output | 1 | Extra edge on the stop channel after its capture |
| start_cap | output | W | Counter value latched on the start edge |
| stop_cap | output | W | Counter value latched on the stop edge |
| interval | output | W | stop_cap minus start_cap, modulo 2^W |

## Verification
The properties assume that `done_clr` is a single-cycle pulse driven from the same clock. They also assume that filter codes change only while both inputs have been low long enough for the filters to settle. The bench changes every input half a period away from the active edge. It updates filter codes only after holding both inputs low for 400 cycles, which is longer than the slowest filter needs. Only the event inputs are treated as asynchronous, and the synchronizers absorb them.

// File: rtl/edge_interval_timer.sv
module edge_interval_timer #(
  parameter int W = 16,
  parameter int PW = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_in,
  input  logic         stop_in,
  input  logic [3:0]   start_fcode,
  input  logic [3:0]   stop_fcode,
  input  logic         done_clr,
  output logic         done,
  output logic         start_ovr,
  output logic         stop_ovr,
  output logic [W-1:0] start_cap,
  output logic [W-1:0] stop_cap,
  output logic [W-1:0] interval
);

  logic [W-1:0]  cnt;
  logic [PW-1:0] presc;
  logic [1:0]    raw;
  logic [3:0]    fcode [2];

  assign raw      = {stop_in, start_in};
  assign fcode[0] = start_fcode;
  assign fcode[1] = stop_fcode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      presc <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
      presc <= presc + 1'b1;
    end

  for (genvar ch = 0; ch < 2; ch++) begin : ch_g
    logic         s1, s2, filt, prev, lvl, rise, got, ovr, tick;
    logic [5:0]   div;
    logic [3:0]   n, run;
    logic [W-1:0] cap;

    always_comb
      case (fcode[ch])
        4'd1:    begin div = 6'd1;  n = 4'd2; end
        4'd2:    begin div = 6'd1;  n = 4'd4; end
        4'd3:    begin div = 6'd1;  n = 4'd8; end
        4'd4:    begin div = 6'd2;  n = 4'd6; end
        4'd5:    begin div = 6'd2;  n = 4'd8; end
        4'd6:    begin div = 6'd4;  n = 4'd6; end
        4'd7:    begin div = 6'd4;  n = 4'd8; end
        4'd8:    begin div = 6'd8;  n = 4'd6; end
        4'd9:    begin div = 6'd8;  n = 4'd8; end
        4'd10:   begin div = 6'd16; n = 4'd4; end
        4'd11:   begin div = 6'd16; n = 4'd6; end
        4'd12:   begin div = 6'd16; n = 4'd8; end
        4'd13:   begin div = 6'd32; n = 4'd4; end
        4'd14:   begin div = 6'd32; n = 4'd6; end
        4'd15:   begin div = 6'd32; n = 4'd8; end
        default: begin div = 6'd1;  n = 4'd1; end
      endcase

    assign tick = (presc & PW'(div - 6'd1)) == '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= raw[ch];
        s2 <= s1;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run  <= '0;
        filt <= 1'b0;
      end else if (tick) begin
        if (s2 == filt)
          run <= '0;
        else if (run + 1'b1 >= n) begin
          run  <= '0;
          filt <= s2;
        end else
          run <= run + 1'b1;
      end

    assign lvl  = (fcode[ch] == 4'd0) ? s2 : filt;
    assign rise = lvl & ~prev;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        prev <= 1'b0;
      else
        prev <= lvl;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cap <= '0;
        got <= 1'b0;
        ovr <= 1'b0;
      end else if (done_clr) begin
        got <= 1'b0;
        ovr <= 1'b0;
      end else if (rise) begin
        if (!got) begin
          cap <= cnt;
          got <= 1'b1;
        end else
          ovr <= 1'b1;
      end
  end

  assign start_cap = ch_g[0].cap;
  assign stop_cap  = ch_g[1].cap;
  assign start_ovr = ch_g[0].ovr;
  assign stop_ovr  = ch_g[1].ovr;
  assign done      = ch_g[1].got;
  assign interval  = stop_cap - start_cap;

endmodule

module edge_interval_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         done_clr,
  input logic         done,
  input logic         start_ovr,
  input logic         stop_ovr,
  input logic [W-1:0] stop_cap
);

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);

  // R5
  cap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> $stable(stop_cap));

  // R5
  ovr_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ovr) |-> $past(done));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr |=> (!done && !start_ovr && !stop_ovr));

endmodule

bind edge_interval_timer edge_interval_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .done_clr(done_clr), .done(done),
  .start_ovr(start_ovr), .stop_ovr(stop_ovr), .stop_cap(stop_cap)
);

// File: tb/edge_interval_timer_tb.sv
module edge_interval_timer_tb_top;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_in = 1'b0, stop_in = 1'b0, done_clr = 1'b0;
  logic [3:0] start_fcode = 4'd0, stop_fcode = 4'd0;
  logic done, start_ovr, stop_ovr;
  logic [W-1:0] start_cap, stop_cap, interval;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  edge_interval_timer #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .stop_in(stop_in),
    .start_fcode(start_fcode), .stop_fcode(stop_fcode), .done_clr(done_clr),
    .done(done), .start_ovr(start_ovr), .stop_ovr(stop_ovr),
    .start_cap(start_cap), .stop_cap(stop_cap), .interval(interval)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
  endtask

  task automatic drop_both();
    @(negedge clk);
    start_in = 1'b0;
    stop_in  = 1'b0;
    wait_cyc(400);
  endtask

  task automatic run_pair(input int d);
    @(negedge clk);
    start_in = 1'b1;
    if (d == 0) stop_in = 1'b1;
    else begin
      wait_cyc(d);
      stop_in = 1'b1;
    end
    wait_cyc(400);
  endtask

  task automatic t_reset();
    check(done == 0, "R1 done", done, 0);
    check(start_ovr == 0 && stop_ovr == 0, "R1 ovr", {start_ovr, stop_ovr}, 0);
    check(start_cap == 0 && stop_cap == 0, "R1 caps", start_cap + stop_cap, 0);
  endtask

  task automatic t_direct(input int d);
    start_fcode = 0; stop_fcode = 0;
    clear_flags();
    run_pair(d);
    check(done == 1, "R2 done", done, 1);
    check(interval == W'(d), "R2 interval", interval, d);
    drop_both();
  endtask

  task automatic t_wrap();
    clear_flags();
    run_pair(70000);
    check(interval == W'(70000), "R3 wrapped interval", interval, 70000 % 65536);
    drop_both();
  endtask

  task automatic t_start_only();
    clear_flags();
    @(negedge clk) start_in = 1'b1;
    wait_cyc(50);
    check(done == 0, "R4 start alone", done, 0);
    @(negedge clk) stop_in = 1'b1;
    wait_cyc(20);
    check(done == 1, "R4 stop sets done", done, 1);
    wait_cyc(100);
    check(done == 1, "R4 done holds", done, 1);
    drop_both();
  endtask

  task automatic t_overcapture();
    logic [W-1:0] s0, p0;
    clear_flags();
    run_pair(25);
    s0 = start_cap; p0 = stop_cap;
    drop_both();
    run_pair(5);
    check(start_ovr == 1, "R5 start_ovr", start_ovr, 1);
    check(stop_ovr == 1, "R5 stop_ovr", stop_ovr, 1);
    check(start_cap == s0 && stop_cap == p0, "R5 caps kept", interval, W'(p0 - s0));
    drop_both();
    clear_flags();
    check(done == 0 && start_ovr == 0 && stop_ovr == 0, "R6 clear", {done, start_ovr, stop_ovr}, 0);
    run_pair(9);
    check(done == 1 && interval == 9, "R6 re-armed", interval, 9);
    drop_both();
  endtask

  task automatic t_filter(input int code, input int dv, input int nn);
    int lo, hi;
    start_fcode = 0; stop_fcode = 4'(code);
    wait_cyc(400);
    clear_flags();
    run_pair(10);
    lo = 10 + (nn - 1) * dv + 1;
    hi = 10 + nn * dv;
    check(done == 1 && interval >= lo && interval <= hi, "R7 filter latency", interval, lo);
    drop_both();
  endtask

  task automatic t_glitch(input int code, input int len);
    stop_fcode = 4'(code);
    wait_cyc(400);
    clear_flags();
    @(negedge clk) stop_in = 1'b1;
    wait_cyc(len);
    stop_in = 1'b0;
    wait_cyc(400);
    check(done == 0, "R8 glitch rejected", done, 0);
  endtask

  task automatic t_falling();
    stop_fcode = 0;
    wait_cyc(10);
    clear_flags();
    @(negedge clk) stop_in = 1'b1;
    wait_cyc(20);
    clear_flags();
    @(negedge clk) stop_in = 1'b0;
    wait_cyc(20);
    check(done == 0, "R9 falling edge ignored", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_direct(0);
    t_direct(1);
    t_direct(37);
    t_direct(1000);
    t_wrap();
    t_start_only();
    t_overcapture();
    t_filter(1, 1, 2);
    t_filter(6, 4, 6);
    t_filter(15, 32, 8);
    t_glitch(1, 1);
    t_glitch(15, 100);
    t_falling();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule